// File: doc/BRIEF.md
# DMA Channel Register Programming Port

This block is the processor-side register file of a four-channel DMA controller. A host reaches it through a 4-bit address, a select, separate read and write strobes and an 8-bit data bus. Each channel has a 16-bit memory address and a 16-bit byte count. Both are reached one byte at a time. An internal byte pointer picks the byte and flips after every access to one of these registers. Every channel register is held twice. The base copy keeps what the host programmed. The working copy is the one the transfer engine advances. The engine can also restore the working copy from the base copy.

The port also holds the control state shared with the engine: a 6-bit mode field per channel, per-channel mask and software-request bits, an 8-bit command byte, and a status byte. In the status byte, the low nibble holds sticky end-of-count flags and the high nibble shows which channels have a request pending. The working registers, the mode, mask, request and command values, and a per-channel load pulse are exported to the engine. Arbitration and bus cycles belong to the engine and are not part of this block.

Top module: `dma_regport`

## Requirements
- R1: After reset the byte pointer is 0, all four mask bits are 1, software requests, command, end-of-count flags, modes and all address and count registers are 0, and `load_o` is 0.
- R2: Address codes 0000 to 0111 select channel registers: bits 2:1 give the channel, and bit 0 picks address (0) or count (1).
- R3: Byte pointer 0 selects bits 7:0 and 1 selects bits 15:8. It inverts after every accepted read or write of a channel register. A write of any data to code 1100 forces it to 0. No other access changes it.
- R4: A channel register write stores the selected byte into the base copy and loads the whole updated base value into the working copy. A channel register read returns the working copy.
- R5: `upd_i[c]` loads `upd_addr_i`/`upd_cnt_i` slice c into channel c's working copies only. `reload_i[c]` copies both base values of channel c into its working copies and takes priority over `upd_i[c]`. Neither input ever changes a base copy.
- R6: When a host write to a register and an engine update or restore of the same register fall in one cycle, the host write decides that register's working value.
- R7: A write to code 1011 stores data bits 7:2 as the mode of the channel given by data bits 1:0. The modes go out on `mode_o`, channel c at bits 6c+5:6c.
- R8: A write to code 1010 sets the mask bit of the channel in data bits 1:0 to data bit 2. A write to code 1110 loads all four mask bits from data bits 3:0.
- R9: A write to code 1001 sets the software request bit of the channel in data bits 1:0 to data bit 2.
- R10: A write to code 1000 loads the command byte. A read of code 1000 returns status, with bits 3:0 the end-of-count flags and bits 7:4 equal to `sreq_o | dreq_i`. Reads of other non-channel codes return 0, and `rdata_o` is 0 when no read is accepted.
- R11: `tc_i[c]` sets end-of-count flag c, and the flag stays set. A status read clears all flags at the end of that cycle, except a flag whose `tc_i` bit is high in that same cycle.
- R12: A write to code 1101 (master clear) zeroes the byte pointer, sets all masks, clears software requests, command and end-of-count flags, and leaves address, count and mode contents unchanged.
- R13: `load_o[c]` is high for exactly the one cycle after an accepted host write to channel c's address or count register.
- R14: An access is accepted only when `cs_i` is high and exactly one of `rd_i`, `wr_i` is high. Any other combination changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Port select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 4 | Register code |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| upd_i | input | 4 | Per-channel engine write-back of working copies |
| upd_addr_i | input | 64 | Engine address values, channel c at bits 16c+15:16c |
| upd_cnt_i | input | 64 | Engine count values, same packing |
| reload_i | input | 4 | Per-channel restore of working copies from base |
| tc_i | input | 4 | Per-channel end-of-count pulse |
| dreq_i | input | 4 | Hardware request lines, shown in status |
| cur_addr_o | output | 64 | Working address registers |
| cur_cnt_o | output | 64 | Working count registers |
| load_o | output | 4 | One-cycle pulse after a host channel write |
| mode_o | output | 24 | Mode fields, 6 bits per channel |
| mask_o | output | 4 | Mask bits |
| sreq_o | output | 4 | Software request bits |
| cmd_o | output | 8 | Command byte |

## Verification
A byte pointer on the wrong phase shows up on the next channel read or write: a read returns the other half of the working value, and a write lands its byte in the wrong half of `cur_addr_o` or `cur_cnt_o` one cycle later. A base copy that drifted stays hidden until a restore, then appears on the working outputs in the cycle after `reload_i`. Stale end-of-count flags appear in the status byte on the first read after the clearing read. The reference model tracks base copies, pointer and flags independently, so each of these faults is caught in the first cycle it reaches a port.

// File: rtl/dma_regport_pkg.sv
package dma_regport_pkg;
  localparam int NUM_CH  = 4;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int ADDR_W  = CH_W + 2;
  localparam int DATA_W  = 8;
  localparam int REG_W   = 2 * DATA_W;
  localparam int MODE_W  = DATA_W - CH_W;
  localparam int STAT_W  = 2 * NUM_CH;

  // codes within the control region (addr msb = 1)
  localparam logic [ADDR_W-2:0] OP_CMD_STAT = 3'd0;
  localparam logic [ADDR_W-2:0] OP_REQ      = 3'd1;
  localparam logic [ADDR_W-2:0] OP_MASK1    = 3'd2;
  localparam logic [ADDR_W-2:0] OP_MODE     = 3'd3;
  localparam logic [ADDR_W-2:0] OP_PTR_CLR  = 3'd4;
  localparam logic [ADDR_W-2:0] OP_MCLR     = 3'd5;
  localparam logic [ADDR_W-2:0] OP_MASK_ALL = 3'd6;

  typedef struct packed {
    logic            chan_wr;
    logic            chan_rd;
    logic [CH_W-1:0] ch;
    logic            is_cnt;
    logic            cmd_wr;
    logic            stat_rd;
    logic            req_wr;
    logic            mask_wr;
    logic            mode_wr;
    logic            ptr_clr;
    logic            mclr;
    logic            mask_all;
  } dec_t;
endpackage

// File: rtl/dma_regport_decode.sv
module dma_regport_decode
  import dma_regport_pkg::*;
(
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  logic acc;
  assign acc = cs_i & (rd_i ^ wr_i);

  always_comb begin
    dec_o = '0;
    if (acc) begin
      if (!addr_i[ADDR_W-1]) begin
        dec_o.ch      = addr_i[CH_W:1];
        dec_o.is_cnt  = addr_i[0];
        dec_o.chan_wr = wr_i;
        dec_o.chan_rd = rd_i;
      end else begin
        unique case (addr_i[ADDR_W-2:0])
          OP_CMD_STAT: begin
            dec_o.cmd_wr  = wr_i;
            dec_o.stat_rd = rd_i;
          end
          OP_REQ:      dec_o.req_wr   = wr_i;
          OP_MASK1:    dec_o.mask_wr  = wr_i;
          OP_MODE:     dec_o.mode_wr  = wr_i;
          OP_PTR_CLR:  dec_o.ptr_clr  = wr_i;
          OP_MCLR:     dec_o.mclr     = wr_i;
          OP_MASK_ALL: dec_o.mask_all = wr_i;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_regport_ctrl.sv
module dma_regport_ctrl
  import dma_regport_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  dec_t                          dec_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NUM_CH-1:0]             tc_i,
  output logic                          ptr_o,
  output logic [NUM_CH-1:0]             mask_o,
  output logic [NUM_CH-1:0]             sreq_o,
  output logic [NUM_CH-1:0][MODE_W-1:0] mode_o,
  output logic [DATA_W-1:0]             cmd_o,
  output logic [NUM_CH-1:0]             tc_o
);
  logic                          ptr_q;
  logic [NUM_CH-1:0]             mask_q, sreq_q, tc_q;
  logic [NUM_CH-1:0][MODE_W-1:0] mode_q;
  logic [DATA_W-1:0]             cmd_q;
  logic [CH_W-1:0]               sel;

  assign sel = wdata_i[CH_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= 1'b0;
      mask_q <= '1;
      sreq_q <= '0;
      mode_q <= '0;
      cmd_q  <= '0;
      tc_q   <= '0;
    end else begin
      if (dec_i.chan_wr || dec_i.chan_rd) ptr_q <= ~ptr_q;
      if (dec_i.ptr_clr) ptr_q <= 1'b0;
      if (dec_i.cmd_wr) cmd_q <= wdata_i;
      if (dec_i.req_wr) sreq_q[sel] <= wdata_i[CH_W];
      if (dec_i.mask_wr) mask_q[sel] <= wdata_i[CH_W];
      if (dec_i.mask_all) mask_q <= wdata_i[NUM_CH-1:0];
      if (dec_i.mode_wr) mode_q[sel] <= wdata_i[DATA_W-1:CH_W];
      // a flag raised in the reading cycle survives the read
      tc_q <= (dec_i.stat_rd ? '0 : tc_q) | tc_i;
      if (dec_i.mclr) begin
        ptr_q  <= 1'b0;
        mask_q <= '1;
        sreq_q <= '0;
        cmd_q  <= '0;
        tc_q   <= '0;
      end
    end
  end

  assign ptr_o  = ptr_q;
  assign mask_o = mask_q;
  assign sreq_o = sreq_q;
  assign mode_o = mode_q;
  assign cmd_o  = cmd_q;
  assign tc_o   = tc_q;

  // R3
  ptr_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i.chan_wr || dec_i.chan_rd) |=> ptr_q != $past(ptr_q));
  // R12
  mclr_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i.mclr |=> (&mask_q) && (sreq_q == '0) && (cmd_q == '0) && !ptr_q);
  // R11
  tc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i.stat_rd && !dec_i.mclr) |=> tc_q == $past(tc_i));
endmodule

// File: rtl/dma_regport_chan.sv
module dma_regport_chan
  import dma_regport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_addr_i,
  input  logic              wr_cnt_i,
  input  logic              hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              upd_i,
  input  logic [REG_W-1:0]  upd_addr_i,
  input  logic [REG_W-1:0]  upd_cnt_i,
  input  logic              reload_i,
  output logic [REG_W-1:0]  cur_addr_o,
  output logic [REG_W-1:0]  cur_cnt_o,
  output logic              load_o
);
  logic [REG_W-1:0] base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;
  logic [REG_W-1:0] base_addr_d, base_cnt_d;
  logic             load_q;

  function automatic logic [REG_W-1:0] put_byte(input logic [REG_W-1:0] v,
                                                input logic hi,
                                                input logic [DATA_W-1:0] b);
    logic [REG_W-1:0] r;
    r = v;
    if (hi) r[REG_W-1:DATA_W] = b;
    else    r[DATA_W-1:0]     = b;
    return r;
  endfunction

  assign base_addr_d = wr_addr_i ? put_byte(base_addr_q, hi_i, wdata_i) : base_addr_q;
  assign base_cnt_d  = wr_cnt_i  ? put_byte(base_cnt_q,  hi_i, wdata_i) : base_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
      load_q      <= 1'b0;
    end else begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      load_q      <= wr_addr_i | wr_cnt_i;
      // host write > restore > engine write-back
      if (wr_addr_i)     cur_addr_q <= base_addr_d;
      else if (reload_i) cur_addr_q <= base_addr_q;
      else if (upd_i)    cur_addr_q <= upd_addr_i;
      if (wr_cnt_i)      cur_cnt_q  <= base_cnt_d;
      else if (reload_i) cur_cnt_q  <= base_cnt_q;
      else if (upd_i)    cur_cnt_q  <= upd_cnt_i;
    end
  end

  assign cur_addr_o = cur_addr_q;
  assign cur_cnt_o  = cur_cnt_q;
  assign load_o     = load_q;

  // R5
  base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_addr_i && !wr_cnt_i) |=> base_addr_q == $past(base_addr_q) && base_cnt_q == $past(base_cnt_q));
  // R5
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && !wr_addr_i && !wr_cnt_i) |=> cur_addr_q == $past(base_addr_q) && cur_cnt_q == $past(base_cnt_q));
  // R4
  write_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_addr_i |=> cur_addr_q == base_addr_q);
endmodule

// File: rtl/dma_regport.sv
module dma_regport
  import dma_regport_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_i,
  input  logic                       rd_i,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic [NUM_CH-1:0]          upd_i,
  input  logic [NUM_CH*REG_W-1:0]    upd_addr_i,
  input  logic [NUM_CH*REG_W-1:0]    upd_cnt_i,
  input  logic [NUM_CH-1:0]          reload_i,
  input  logic [NUM_CH-1:0]          tc_i,
  input  logic [NUM_CH-1:0]          dreq_i,
  output logic [NUM_CH*REG_W-1:0]    cur_addr_o,
  output logic [NUM_CH*REG_W-1:0]    cur_cnt_o,
  output logic [NUM_CH-1:0]          load_o,
  output logic [NUM_CH*MODE_W-1:0]   mode_o,
  output logic [NUM_CH-1:0]          mask_o,
  output logic [NUM_CH-1:0]          sreq_o,
  output logic [DATA_W-1:0]          cmd_o
);
  dec_t                          dec;
  logic                          ptr;
  logic [NUM_CH-1:0]             tc, sreq;
  logic [NUM_CH-1:0][MODE_W-1:0] mode;
  logic [NUM_CH-1:0][REG_W-1:0]  cur_a, cur_c;
  logic [REG_W-1:0]              rsel;

  dma_regport_decode u_decode (
    .cs_i   (cs_i),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  dma_regport_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dec_i   (dec),
    .wdata_i (wdata_i),
    .tc_i    (tc_i),
    .ptr_o   (ptr),
    .mask_o  (mask_o),
    .sreq_o  (sreq),
    .mode_o  (mode),
    .cmd_o   (cmd_o),
    .tc_o    (tc)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic hit;
    assign hit = dec.chan_wr && (dec.ch == CH_W'(g));
    dma_regport_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_addr_i  (hit && !dec.is_cnt),
      .wr_cnt_i   (hit && dec.is_cnt),
      .hi_i       (ptr),
      .wdata_i    (wdata_i),
      .upd_i      (upd_i[g]),
      .upd_addr_i (upd_addr_i[g*REG_W +: REG_W]),
      .upd_cnt_i  (upd_cnt_i[g*REG_W +: REG_W]),
      .reload_i   (reload_i[g]),
      .cur_addr_o (cur_a[g]),
      .cur_cnt_o  (cur_c[g]),
      .load_o     (load_o[g])
    );
  end

  assign rsel = dec.is_cnt ? cur_c[dec.ch] : cur_a[dec.ch];

  always_comb begin
    rdata_o = '0;
    if (dec.chan_rd)      rdata_o = ptr ? rsel[REG_W-1:DATA_W] : rsel[DATA_W-1:0];
    else if (dec.stat_rd) rdata_o = {sreq | dreq_i, tc};
  end

  assign cur_addr_o = cur_a;
  assign cur_cnt_o  = cur_c;
  assign mode_o     = mode;
  assign sreq_o     = sreq;

  // R13
  load_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(load_o));
  // R14
  idle_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> ptr == $past(ptr));
  // R14
  idle_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i == wr_i) |=> load_o == '0);
endmodule

// File: tb/dma_regport_bench.sv
module dma_regport_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 0, rd = 0, wr = 0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  upd = '0, reload = '0, tc_in = '0, dreq = '0;
  logic [63:0] upd_addr = '0, upd_cnt = '0;
  logic [63:0] cur_addr, cur_cnt;
  logic [3:0]  load, mask, sreq;
  logic [23:0] mode;
  logic [7:0]  cmd;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_base_a[4], m_base_c[4], m_cur_a[4], m_cur_c[4];
  logic [5:0]  m_mode[4];
  logic        m_ptr;
  logic [3:0]  m_mask, m_sreq, m_tc, m_load;
  logic [7:0]  m_cmd;

  always #5 clk = ~clk;

  dma_regport u_dma_regport (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .upd_i(upd), .upd_addr_i(upd_addr), .upd_cnt_i(upd_cnt),
    .reload_i(reload), .tc_i(tc_in), .dreq_i(dreq),
    .cur_addr_o(cur_addr), .cur_cnt_o(cur_cnt), .load_o(load),
    .mode_o(mode), .mask_o(mask), .sreq_o(sreq), .cmd_o(cmd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      m_base_a[c] = 0; m_base_c[c] = 0; m_cur_a[c] = 0; m_cur_c[c] = 0; m_mode[c] = 0;
    end
    m_ptr = 0; m_mask = 4'hf; m_sreq = 0; m_tc = 0; m_load = 0; m_cmd = 0;
  endtask

  function automatic logic [7:0] exp_rdata();
    logic [15:0] v;
    if (!(cs && rd && !wr)) return 8'h00;
    if (!addr[3]) begin
      v = addr[0] ? m_cur_c[addr[2:1]] : m_cur_a[addr[2:1]];
      return m_ptr ? v[15:8] : v[7:0];
    end
    if (addr == 4'b1000) return {m_sreq | dreq, m_tc};
    return 8'h00;
  endfunction

  task automatic model_update();
    bit acc;
    logic [15:0] na, nc;
    int ch;
    if (!rst_n) begin model_reset(); return; end
    acc = cs && (rd ^ wr);
    ch  = addr[2:1];
    m_load = 0;
    for (int c = 0; c < 4; c++) begin
      bit wa, wc;
      wa = acc && wr && !addr[3] && ch == c && !addr[0];
      wc = acc && wr && !addr[3] && ch == c &&  addr[0];
      na = m_base_a[c]; nc = m_base_c[c];
      if (wa) begin if (m_ptr) na[15:8] = wdata; else na[7:0] = wdata; end
      if (wc) begin if (m_ptr) nc[15:8] = wdata; else nc[7:0] = wdata; end
      if (wa)             m_cur_a[c] = na;
      else if (reload[c]) m_cur_a[c] = m_base_a[c];
      else if (upd[c])    m_cur_a[c] = upd_addr[c*16 +: 16];
      if (wc)             m_cur_c[c] = nc;
      else if (reload[c]) m_cur_c[c] = m_base_c[c];
      else if (upd[c])    m_cur_c[c] = upd_cnt[c*16 +: 16];
      m_base_a[c] = na; m_base_c[c] = nc;
      if (wa || wc) m_load[c] = 1'b1;
    end
    m_tc = ((acc && rd && addr == 4'b1000) ? 4'h0 : m_tc) | tc_in;
    if (acc && !addr[3]) m_ptr = ~m_ptr;
    if (acc && wr && addr[3]) begin
      case (addr[2:0])
        3'd0: m_cmd = wdata;
        3'd1: m_sreq[wdata[1:0]] = wdata[2];
        3'd2: m_mask[wdata[1:0]] = wdata[2];
        3'd3: m_mode[wdata[1:0]] = wdata[7:2];
        3'd4: m_ptr = 0;
        3'd5: begin m_ptr = 0; m_mask = 4'hf; m_sreq = 0; m_cmd = 0; m_tc = 0; end
        3'd6: m_mask = wdata[3:0];
        default: ;
      endcase
    end
  endtask

  task automatic check_all();
    for (int c = 0; c < 4; c++) begin
      chk("R4 cur_addr", {16'h0, cur_addr[c*16 +: 16]}, {16'h0, m_cur_a[c]});
      chk("R4 cur_cnt",  {16'h0, cur_cnt[c*16 +: 16]},  {16'h0, m_cur_c[c]});
      chk("R7 mode",     {26'h0, mode[c*6 +: 6]},       {26'h0, m_mode[c]});
    end
    chk("R8 mask", {28'h0, mask}, {28'h0, m_mask});
    chk("R9 sreq", {28'h0, sreq}, {28'h0, m_sreq});
    chk("R10 cmd", {24'h0, cmd},  {24'h0, m_cmd});
    chk("R13 load", {28'h0, load}, {28'h0, m_load});
    chk("R3 rdata", {24'h0, rdata}, {24'h0, exp_rdata()});
  endtask

  // inputs are applied after the falling edge; model advances at the rising edge
  task automatic step(input logic c, input logic r, input logic w,
                      input logic [3:0] a, input logic [7:0] d);
    cs = c; rd = r; wr = w; addr = a; wdata = d;
    #1 check_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
    upd = 0; reload = 0; tc_in = 0;
    cs = 0; rd = 0; wr = 0;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d); step(1, 0, 1, a, d); endtask
  task automatic rreg(input logic [3:0] a); step(1, 1, 0, a, 8'h00); endtask
  task automatic idle(); step(0, 0, 0, 4'h0, 8'h00); endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] v);
    cs = 1; rd = 1; wr = 0; addr = a;
    #1 v = rdata;
    cs = 0; rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 mask", {28'h0, mask}, 32'hf);
    chk("R1 cmd", {24'h0, cmd}, 32'h0);
    chk("R1 cur_addr", cur_addr[31:0], 32'h0);
    peek(4'b1000, v); chk("R1 status", {24'h0, v}, 32'h0);
    idle();
    // R4 / R13 ch0 address, low then high
    wreg(4'b0000, 8'h34);
    wreg(4'b0000, 8'h12);
    chk("R4 ch0 addr", {16'h0, cur_addr[15:0]}, 32'h1234);
    chk("R13 load pulse", {28'h0, load}, 32'h1);
    idle();
    chk("R13 load drops", {28'h0, load}, 32'h0);
    // R2 ch2 count decode
    wreg(4'b0101, 8'hEF);
    wreg(4'b0101, 8'hBE);
    chk("R2 ch2 cnt", {16'h0, cur_cnt[47:32]}, 32'hBEEF);
    chk("R2 ch1 cnt", {16'h0, cur_cnt[31:16]}, 32'h0);
    chk("R2 ch2 addr", {16'h0, cur_addr[47:32]}, 32'h0);
    // R3 reading alternates bytes
    peek(4'b0101, v); chk("R3 low byte", {24'h0, v}, 32'hEF);
    rreg(4'b0101);
    peek(4'b0101, v); chk("R3 high byte", {24'h0, v}, 32'hBE);
    rreg(4'b0101);
    // R3 pointer clear
    wreg(4'b0000, 8'h56);
    wreg(4'b1100, 8'hA5);
    wreg(4'b0000, 8'h78);
    chk("R3 ptr clear", {16'h0, cur_addr[15:0]}, 32'h1278);
    wreg(4'b1100, 8'h00);
    // R5 engine write-back then restore
    upd = 4'b0100; upd_cnt[47:32] = 16'h0003; upd_addr[47:32] = 16'h4000;
    idle();
    chk("R5 upd cnt", {16'h0, cur_cnt[47:32]}, 32'h0003);
    chk("R5 upd addr", {16'h0, cur_addr[47:32]}, 32'h4000);
    reload = 4'b0100; upd = 4'b0100;
    idle();
    chk("R5 reload cnt", {16'h0, cur_cnt[47:32]}, 32'hBEEF);
    chk("R5 reload addr", {16'h0, cur_addr[47:32]}, 32'h0);
    // R6 host write beats engine update
    upd = 4'b0100; upd_cnt[47:32] = 16'h7777;
    wreg(4'b0101, 8'h11);
    chk("R6 collision", {16'h0, cur_cnt[47:32]}, 32'hBE11);
    wreg(4'b1100, 8'h00);
    // R7 mode
    wreg(4'b1011, 8'hAB);
    chk("R7 ch3 mode", {26'h0, mode[23:18]}, 32'h2A);
    // R8 masks
    wreg(4'b1110, 8'h00);
    wreg(4'b1010, 8'h05);
    chk("R8 mask single", {28'h0, mask}, 32'h2);
    // R9 / R10 requests, status, command
    wreg(4'b1001, 8'h06);
    chk("R9 sreq", {28'h0, sreq}, 32'h4);
    dreq = 4'b0001;
    peek(4'b1000, v); chk("R10 status pending", {24'h0, v}, 32'h50);
    peek(4'b1001, v); chk("R10 other code reads 0", {24'h0, v}, 32'h0);
    wreg(4'b1000, 8'hC3);
    chk("R10 cmd", {24'h0, cmd}, 32'hC3);
    // R11 end-of-count flags
    tc_in = 4'b0010;
    idle();
    peek(4'b1000, v); chk("R11 tc set", {24'h0, v}, 32'h52);
    tc_in = 4'b1000;
    rreg(4'b1000);
    peek(4'b1000, v); chk("R11 tc during read kept", {24'h0, v}, 32'h58);
    rreg(4'b1000);
    peek(4'b1000, v); chk("R11 tc cleared", {24'h0, v}, 32'h50);
    // R12 master clear
    wreg(4'b0010, 8'h9A);
    tc_in = 4'b0001;
    idle();
    wreg(4'b1101, 8'h00);
    chk("R12 mask", {28'h0, mask}, 32'hf);
    chk("R12 sreq", {28'h0, sreq}, 32'h0);
    chk("R12 cmd", {24'h0, cmd}, 32'h0);
    chk("R12 addr kept", {16'h0, cur_addr[15:0]}, 32'h1278);
    chk("R12 mode kept", {26'h0, mode[23:18]}, 32'h2A);
    peek(4'b1000, v); chk("R12 status", {24'h0, v}, 32'h10);
    peek(4'b0000, v); chk("R12 ptr zero", {24'h0, v}, 32'h78);
    // R14 rejected accesses
    step(0, 0, 1, 4'b0000, 8'hFF);
    step(1, 1, 1, 4'b0000, 8'hFF);
    step(1, 1, 1, 4'b1101, 8'hFF);
    chk("R14 addr kept", {16'h0, cur_addr[15:0]}, 32'h1278);
    chk("R14 no load", {28'h0, load}, 32'h0);
    peek(4'b0000, v); chk("R14 ptr kept", {24'h0, v}, 32'h78);
    // mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      upd = 4'($urandom); reload = 4'($urandom) & 4'($urandom);
      tc_in = 4'($urandom) & 4'($urandom); dreq = 4'($urandom);
      upd_addr = {$urandom, $urandom}; upd_cnt = {$urandom, $urandom};
      step(($urandom % 5) != 0, 1'($urandom), 1'($urandom), 4'($urandom), 8'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule